// File: doc/BRIEF.md
# Time Reference Selection Supervisor

This block picks one of several time-reference inputs for a local PLL and follows the quality of the resulting time base. It sees one health flag per input and always selects the highest-priority healthy one (index 0 ranks first). A small state machine tracks free-run, acquisition, lock and holdover from the PLL lock indication. A detector checks successive samples of the local time counter for steps that leave a programmable window.

The block drives the mux select and an alarm vector. It also raises a degrade request that tells the gate scheduler to drop to measurement-only operation whenever the time base cannot be trusted. Reference changes, lock losses, holdover exits, holdover overruns and time steps are written as records to a small event queue, each with a measured duration. Host logic drains the queue with a read strobe.

When several events occur in the same cycle, each is parked in a per-type slot. The slots drain into the queue one per cycle, lowest type code first.

Top module: `tref_supervisor`

## Requirements
- R1: `mux_sel` names the lowest-indexed input whose `ref_ok` bit is set. When no bit is set, `sel_valid` is 0 and `mux_sel` keeps its last value. Both outputs change one clock edge after `ref_ok` changes.
- R2: If the selected input becomes unhealthy, or nothing was selected, the block switches to the best healthy input at the next edge. After any switch, a move to a higher-priority input is held off until `cfg_lockout` further edges have passed.
- R3: After a switch, the first rising edge seen on `pll_lock` logs event type 0. The record carries the new `mux_sel` and, as its duration, the number of clock edges from the switching edge to the edge that first samples `pll_lock` high.
- R4: `state` is encoded as 0 free-run, 1 acquiring, 2 locked and 3 holdover, and reset gives 0. Moves are: 0→1 when an input is selected; 1→2 when `pll_lock` is high; 1→0 when nothing is selected; 2→3 when lock or selection is lost; 3→1 when `pll_lock` is high and an input is selected.
- R5: Leaving the locked state logs event type 1, with the input active at the failure and the number of edges spent locked. It also sets `alarm[0]` and latches `lol_src`. Both are held until the locked state is reached again.
- R6: `alarm[1]` is high while in holdover. Leaving holdover logs event type 2, with the number of edges spent in holdover.
- R7: When holdover lasts `cfg_hold_max` edges, `alarm[3]` is set and event type 4 is logged with duration `cfg_hold_max`. `alarm[3]` clears only on entry to the locked state.
- R8: On each `tcount_vld` sample after the first since reset, the step d = `tcount` − previous sample, taken modulo 2^TS_W, is compared with the window [`cfg_step`−`cfg_tol`, `cfg_step`+`cfg_tol`]. A step outside the window raises `alarm[2]` for the one cycle after the sampling edge and logs event type 3, with d as its duration.
- R9: `degrade` is high whenever `state` is not 2, and during any cycle in which `alarm[2]` is high.
- R10: `ev_valid` shows that a record is at the head of the queue. The head's `ev_type`, `ev_src` and `ev_dur` stay stable until `ev_rd` is sampled high, which removes it. Records come out in the order they were logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | N_REF | Health flag per reference input |
| pll_lock | input | 1 | PLL lock indication |
| tcount | input | TS_W | Local time counter sample |
| tcount_vld | input | 1 | `tcount` holds a new sample |
| cfg_lockout | input | LOCK_W | Edges during which upgrades are held off after a switch |
| cfg_step | input | TS_W | Expected increment between samples |
| cfg_tol | input | TS_W | Allowed deviation from `cfg_step` |
| cfg_hold_max | input | DUR_W | Holdover length that triggers the service alarm |
| mux_sel | output | IDX_W | Selected reference index |
| sel_valid | output | 1 | A healthy reference is selected |
| state | output | 2 | Lock state |
| alarm | output | 4 | {service, time jump, holdover, lock lost} |
| lol_src | output | IDX_W | Input active at the last lock loss |
| degrade | output | 1 | Request measurement-only gating |
| ev_valid | output | 1 | Event record available |
| ev_type | output | 3 | Event type of head record |
| ev_src | output | IDX_W | Source index of head record |
| ev_dur | output | DUR_W | Duration or step of head record |
| ev_rd | input | 1 | Remove head record |

## Verification
The bench targets the lockout window on both sides. An upgrade that fires one edge early, or a forced switch that wrongly waits out the lockout, shows up as a wrong `mux_sel` at a fixed cycle. Time steps are placed exactly on both window edges, one count past each edge, and across counter wraparound. An off-by-one compare or a signed subtraction would flag a good step or miss a bad one. Holdover is run both shorter and longer than the limit, and the durations are checked in the logged records. A counter that starts at the wrong value, or a service alarm that clears on holdover exit instead of on relock, produces a wrong duration or a stuck alarm. The state with no healthy input is also checked: a design that dropped its select value there would move `mux_sel`.

// File: rtl/tref_pkg.sv
package tref_pkg;
   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_ACQ  = 2'd1,
      ST_LOCK = 2'd2,
      ST_HOLD = 2'd3
   } tref_state_e;

   localparam int EV_TYPE_W = 3;
   localparam int N_EV      = 5;
   localparam logic [EV_TYPE_W-1:0] EV_SWITCH = 3'd0;
   localparam logic [EV_TYPE_W-1:0] EV_LOSS   = 3'd1;
   localparam logic [EV_TYPE_W-1:0] EV_HEXIT  = 3'd2;
   localparam logic [EV_TYPE_W-1:0] EV_JUMP   = 3'd3;
   localparam logic [EV_TYPE_W-1:0] EV_HLIMIT = 3'd4;
endpackage

// File: rtl/tref_select.sv
module tref_select #(
   parameter int N_REF  = 4,
   parameter int LOCK_W = 16,
   parameter int DUR_W  = 32,
   localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REF-1:0]  ref_ok,
   input  logic              pll_lock,
   input  logic [LOCK_W-1:0] cfg_lockout,
   output logic [IDX_W-1:0]  sel,
   output logic              sel_vld,
   output logic              relock_stb,
   output logic [DUR_W-1:0]  relock_dur
);
   logic [IDX_W-1:0]  best;
   logic              any_ok, cur_ok, forced, upgrade, do_sw;
   logic [LOCK_W-1:0] hold_cnt;
   logic [DUR_W-1:0]  rl_cnt;
   logic              rl_pend, lock_q;

   // fixed priority: lowest healthy index wins
   always_comb begin
      best = '0;
      for (int i = N_REF - 1; i >= 0; i--)
         if (ref_ok[i]) best = IDX_W'(i);
   end

   assign any_ok  = |ref_ok;
   assign cur_ok  = ref_ok[sel];
   assign forced  = any_ok && (!sel_vld || !cur_ok);
   assign upgrade = any_ok && sel_vld && cur_ok && (best < sel) && (hold_cnt == '0);
   assign do_sw   = forced || upgrade;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel        <= '0;
         sel_vld    <= 1'b0;
         hold_cnt   <= '0;
         rl_cnt     <= '0;
         rl_pend    <= 1'b0;
         lock_q     <= 1'b0;
         relock_stb <= 1'b0;
         relock_dur <= '0;
      end else begin
         lock_q     <= pll_lock;
         relock_stb <= 1'b0;
         if (!any_ok)
            sel_vld <= 1'b0;
         if (do_sw) begin
            sel      <= best;
            sel_vld  <= 1'b1;
            hold_cnt <= cfg_lockout;
            rl_pend  <= 1'b1;
            rl_cnt   <= DUR_W'(1);
         end else begin
            if (hold_cnt != '0)
               hold_cnt <= hold_cnt - 1'b1;
            if (rl_pend) begin
               if (pll_lock && !lock_q) begin
                  rl_pend    <= 1'b0;
                  relock_stb <= 1'b1;
                  relock_dur <= rl_cnt;
               end else if (rl_cnt != '1) begin
                  rl_cnt <= rl_cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tref_lockfsm.sv
module tref_lockfsm
   import tref_pkg::*;
#(
   parameter int IDX_W = 2,
   parameter int DUR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_vld,
   input  logic [IDX_W-1:0] sel,
   input  logic             pll_lock,
   input  logic [DUR_W-1:0] cfg_hold_max,
   output tref_state_e      st,
   output logic             svc,
   output logic             lol_alarm,
   output logic [IDX_W-1:0] lol_src,
   output logic             loss_stb,
   output logic [DUR_W-1:0] loss_dur,
   output logic             exit_stb,
   output logic [DUR_W-1:0] exit_dur,
   output logic             lim_stb
);
   tref_state_e      nxt;
   logic [DUR_W-1:0] st_cnt;

   always_comb begin
      nxt = st;
      unique case (st)
         ST_FREE: if (sel_vld) nxt = ST_ACQ;
         ST_ACQ:  if (!sel_vld) nxt = ST_FREE;
                  else if (pll_lock) nxt = ST_LOCK;
         ST_LOCK: if (!pll_lock || !sel_vld) nxt = ST_HOLD;
         ST_HOLD: if (pll_lock && sel_vld) nxt = ST_ACQ;
         default: nxt = ST_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_FREE;
         st_cnt    <= '0;
         svc       <= 1'b0;
         lol_alarm <= 1'b0;
         lol_src   <= '0;
         loss_stb  <= 1'b0;
         loss_dur  <= '0;
         exit_stb  <= 1'b0;
         exit_dur  <= '0;
         lim_stb   <= 1'b0;
      end else begin
         st       <= nxt;
         loss_stb <= 1'b0;
         exit_stb <= 1'b0;
         lim_stb  <= 1'b0;
         if (nxt != st)
            st_cnt <= DUR_W'(1);
         else if (st_cnt != '1)
            st_cnt <= st_cnt + 1'b1;
         if (st == ST_LOCK && nxt == ST_HOLD) begin
            loss_stb  <= 1'b1;
            loss_dur  <= st_cnt;
            lol_alarm <= 1'b1;
            lol_src   <= sel;
         end
         if (st == ST_HOLD && nxt == ST_ACQ) begin
            exit_stb <= 1'b1;
            exit_dur <= st_cnt;
         end
         if (st == ST_HOLD && nxt == ST_HOLD && st_cnt == cfg_hold_max) begin
            svc     <= 1'b1;
            lim_stb <= 1'b1;
         end
         if (nxt == ST_LOCK) begin
            svc       <= 1'b0;
            lol_alarm <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tref_jumpdet.sv
module tref_jumpdet #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [TS_W-1:0] tcount,
   input  logic            tcount_vld,
   input  logic [TS_W-1:0] cfg_step,
   input  logic [TS_W-1:0] cfg_tol,
   output logic            jump_stb,
   output logic [TS_W-1:0] jump_delta
);
   logic [TS_W-1:0] prev, delta, lo;
   logic [TS_W:0]   lo_ext, hi_ext;
   logic            have_prev, outside;

   assign delta   = tcount - prev;
   assign lo_ext  = {1'b0, cfg_step} - {1'b0, cfg_tol};
   assign lo      = lo_ext[TS_W] ? '0 : lo_ext[TS_W-1:0];
   assign hi_ext  = {1'b0, cfg_step} + {1'b0, cfg_tol};
   assign outside = ({1'b0, delta} < {1'b0, lo}) || ({1'b0, delta} > hi_ext);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev       <= '0;
         have_prev  <= 1'b0;
         jump_stb   <= 1'b0;
         jump_delta <= '0;
      end else begin
         jump_stb <= 1'b0;
         if (tcount_vld) begin
            prev      <= tcount;
            have_prev <= 1'b1;
            if (have_prev && outside) begin
               jump_stb   <= 1'b1;
               jump_delta <= delta;
            end
         end
      end
   end
endmodule

// File: rtl/tref_evq.sv
module tref_evq #(
   parameter int W     = 37,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          push, pop;

   assign empty = (cnt == '0);
   assign full  = (cnt == (AW+1)'(DEPTH));
   assign push  = wr && !full;
   assign pop   = rd && !empty;
   assign rdata = mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      end
   end
endmodule

// File: rtl/tref_supervisor.sv
module tref_supervisor
   import tref_pkg::*;
#(
   parameter int N_REF     = 4,
   parameter int TS_W      = 32,
   parameter int DUR_W     = 32,
   parameter int LOCK_W    = 16,
   parameter int EVQ_DEPTH = 8,
   localparam int IDX_W    = (N_REF > 1) ? $clog2(N_REF) : 1,
   localparam int REC_W    = EV_TYPE_W + IDX_W + DUR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REF-1:0]  ref_ok,
   input  logic              pll_lock,
   input  logic [TS_W-1:0]   tcount,
   input  logic              tcount_vld,
   input  logic [LOCK_W-1:0] cfg_lockout,
   input  logic [TS_W-1:0]   cfg_step,
   input  logic [TS_W-1:0]   cfg_tol,
   input  logic [DUR_W-1:0]  cfg_hold_max,
   output logic [IDX_W-1:0]  mux_sel,
   output logic              sel_valid,
   output logic [1:0]        state,
   output logic [3:0]        alarm,
   output logic [IDX_W-1:0]  lol_src,
   output logic              degrade,
   output logic              ev_valid,
   output logic [2:0]        ev_type,
   output logic [IDX_W-1:0]  ev_src,
   output logic [DUR_W-1:0]  ev_dur,
   input  logic              ev_rd
);
   if (N_REF < 2 || N_REF > 8) begin : g_bad_nref
      $error("N_REF must lie in 2..8");
   end
   if (DUR_W < TS_W) begin : g_bad_dur
      $error("DUR_W must be at least TS_W");
   end
   if (EVQ_DEPTH < 2 || (EVQ_DEPTH & (EVQ_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("EVQ_DEPTH must be a power of two >= 2");
   end

   tref_state_e      st;
   logic             svc, lol_alarm;
   logic             relock_stb, loss_stb, exit_stb, lim_stb, jump_stb;
   logic [DUR_W-1:0] relock_dur, loss_dur, exit_dur;
   logic [TS_W-1:0]  jump_delta;

   tref_select #(.N_REF(N_REF), .LOCK_W(LOCK_W), .DUR_W(DUR_W)) u_sel (
      .clk, .rst_n, .ref_ok, .pll_lock, .cfg_lockout,
      .sel(mux_sel), .sel_vld(sel_valid), .relock_stb, .relock_dur);

   tref_lockfsm #(.IDX_W(IDX_W), .DUR_W(DUR_W)) u_fsm (
      .clk, .rst_n, .sel_vld(sel_valid), .sel(mux_sel), .pll_lock, .cfg_hold_max,
      .st, .svc, .lol_alarm, .lol_src, .loss_stb, .loss_dur,
      .exit_stb, .exit_dur, .lim_stb);

   tref_jumpdet #(.TS_W(TS_W)) u_jmp (
      .clk, .rst_n, .tcount, .tcount_vld, .cfg_step, .cfg_tol,
      .jump_stb, .jump_delta);

   // event slots, one per type, drained lowest type first
   logic [N_EV-1:0]  set_v, pend;
   logic [IDX_W-1:0] set_src [N_EV];
   logic [DUR_W-1:0] set_dur [N_EV];
   logic [IDX_W-1:0] slot_src [N_EV];
   logic [DUR_W-1:0] slot_dur [N_EV];
   logic [EV_TYPE_W-1:0] pick;
   logic             q_wr, q_empty, q_full;
   logic [REC_W-1:0] q_rdata;

   assign set_v[EV_SWITCH] = relock_stb;
   assign set_src[EV_SWITCH] = mux_sel;
   assign set_dur[EV_SWITCH] = relock_dur;
   assign set_v[EV_LOSS] = loss_stb;
   assign set_src[EV_LOSS] = lol_src;
   assign set_dur[EV_LOSS] = loss_dur;
   assign set_v[EV_HEXIT] = exit_stb;
   assign set_src[EV_HEXIT] = mux_sel;
   assign set_dur[EV_HEXIT] = exit_dur;
   assign set_v[EV_JUMP] = jump_stb;
   assign set_src[EV_JUMP] = mux_sel;
   assign set_dur[EV_JUMP] = DUR_W'(jump_delta);
   assign set_v[EV_HLIMIT] = lim_stb;
   assign set_src[EV_HLIMIT] = mux_sel;
   assign set_dur[EV_HLIMIT] = cfg_hold_max;

   always_comb begin
      pick = '0;
      for (int i = N_EV - 1; i >= 0; i--)
         if (pend[i]) pick = EV_TYPE_W'(i);
   end

   assign q_wr = (|pend) && !q_full;

   for (genvar g = 0; g < N_EV; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[g]     <= 1'b0;
            slot_src[g] <= '0;
            slot_dur[g] <= '0;
         end else if (set_v[g]) begin
            pend[g]     <= 1'b1;
            slot_src[g] <= set_src[g];
            slot_dur[g] <= set_dur[g];
         end else if (q_wr && pick == EV_TYPE_W'(g)) begin
            pend[g] <= 1'b0;
         end
      end
   end

   tref_evq #(.W(REC_W), .DEPTH(EVQ_DEPTH)) u_q (
      .clk, .rst_n, .wr(q_wr),
      .wdata({pick, slot_src[pick], slot_dur[pick]}),
      .rd(ev_rd), .rdata(q_rdata), .empty(q_empty), .full(q_full));

   assign ev_valid = !q_empty;
   assign {ev_type, ev_src, ev_dur} = q_rdata;

   assign state   = st;
   assign alarm   = {svc, jump_stb, st == ST_HOLD, lol_alarm};
   assign degrade = (st != ST_LOCK) || jump_stb;
endmodule

// File: rtl/tref_supervisor_chk.sv
module tref_supervisor_chk #(
   parameter int N_REF = 4,
   parameter int IDX_W = 2,
   parameter int DUR_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_REF-1:0] ref_ok,
   input logic [IDX_W-1:0] mux_sel,
   input logic             sel_valid,
   input logic [1:0]       state,
   input logic [3:0]       alarm,
   input logic [IDX_W-1:0] lol_src,
   input logic             degrade,
   input logic             ev_valid,
   input logic             ev_rd,
   input logic [2:0]       ev_type,
   input logic [IDX_W-1:0] ev_src,
   input logic [DUR_W-1:0] ev_dur
);
   logic [N_REF-1:0] ok_q;
   always_ff @(posedge clk) begin
      if (!rst_n) ok_q <= '0;
      else        ok_q <= ref_ok;
   end

   // R1
   sel_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> ok_q[mux_sel]);

   // R1
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_valid && !$past(sel_valid)) |-> $stable(mux_sel));

   // R9
   degrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != 2'd2) |-> degrade);

   // R5
   lol_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3) |-> alarm[0]);

   // R5
   lol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd3 && $past(state) == 2'd3) |-> $stable(lol_src));

   // R7
   svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm[3] |-> (state != 2'd2));

   // R10
   ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_rd) |=> (ev_valid && $stable(ev_type) && $stable(ev_src) && $stable(ev_dur)));
endmodule

bind tref_supervisor tref_supervisor_chk #(.N_REF(N_REF), .IDX_W(IDX_W), .DUR_W(DUR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .mux_sel(mux_sel), .sel_valid(sel_valid),
   .state(state), .alarm(alarm), .lol_src(lol_src), .degrade(degrade),
   .ev_valid(ev_valid), .ev_rd(ev_rd), .ev_type(ev_type), .ev_src(ev_src), .ev_dur(ev_dur));

// File: tb/tb_tref_supervisor.sv
`timescale 1ns/1ps
module tb_tref_supervisor;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  ref_ok;
   logic        pll_lock;
   logic [31:0] tcount;
   logic        tcount_vld;
   logic [15:0] cfg_lockout;
   logic [31:0] cfg_step, cfg_tol, cfg_hold_max;
   logic [1:0]  mux_sel;
   logic        sel_valid;
   logic [1:0]  state;
   logic [3:0]  alarm;
   logic [1:0]  lol_src;
   logic        degrade;
   logic        ev_valid;
   logic [2:0]  ev_type;
   logic [1:0]  ev_src;
   logic [31:0] ev_dur;
   logic        ev_rd;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   tref_supervisor dut (
      .clk, .rst_n, .ref_ok, .pll_lock, .tcount, .tcount_vld,
      .cfg_lockout, .cfg_step, .cfg_tol, .cfg_hold_max,
      .mux_sel, .sel_valid, .state, .alarm, .lol_src, .degrade,
      .ev_valid, .ev_type, .ev_src, .ev_dur, .ev_rd);

   // {ref_ok[3:0], expected sel[1:0], expected sel_valid}
   localparam logic [6:0] VEC [10] = '{
      {4'b1111, 2'd0, 1'b1},
      {4'b1110, 2'd1, 1'b1},
      {4'b1100, 2'd2, 1'b1},
      {4'b1000, 2'd3, 1'b1},
      {4'b1010, 2'd1, 1'b1},
      {4'b0000, 2'd1, 1'b0},
      {4'b0101, 2'd0, 1'b1},
      {4'b0100, 2'd2, 1'b1},
      {4'b0001, 2'd0, 1'b1},
      {4'b1111, 2'd0, 1'b1}
   };

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic read_ev(input string tag, input int t, input int s, input longint d);
      chk({tag, " ev_valid"}, ev_valid, 1);
      chk({tag, " ev_type"}, ev_type, t);
      chk({tag, " ev_src"}, ev_src, s);
      chk({tag, " ev_dur"}, ev_dur, d);
      ev_rd = 1'b1;
      @(negedge clk);
      ev_rd = 1'b0;
   endtask

   task automatic sample(input string tag, input logic [31:0] v, input bit exp_jump);
      tcount     = v;
      tcount_vld = 1'b1;
      @(negedge clk);
      tcount_vld = 1'b0;
      chk({tag, " jump alarm"}, alarm[2], exp_jump);
      chk({tag, " degrade (R9)"}, degrade, exp_jump);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; ref_ok = '0; pll_lock = 1'b0; tcount = '0; tcount_vld = 1'b0;
      cfg_lockout = 16'd0; cfg_step = 32'd100; cfg_tol = 32'd3; cfg_hold_max = 32'd20;
      ev_rd = 1'b0;
      @(negedge clk);
      do_reset();
      // R4 reset state
      chk("R4 reset state", state, 0);
      chk("R1 reset sel_valid", sel_valid, 0);
      chk("R5 reset alarm", alarm, 0);
      chk("R9 reset degrade", degrade, 1);
      chk("R10 reset ev_valid", ev_valid, 0);

      // R1 priority table walk, no lockout
      for (int i = 0; i < 10; i++) begin
         ref_ok = VEC[i][6:3];
         repeat (2) @(negedge clk);
         chk($sformatf("R1 vec%0d mux_sel", i), mux_sel, VEC[i][2:1]);
         chk($sformatf("R1 vec%0d sel_valid", i), sel_valid, VEC[i][0]);
      end

      cfg_lockout = 16'd5;
      ref_ok = '0;
      do_reset();

      // R3/R4 first acquisition
      ref_ok = 4'b0100;
      repeat (3) @(negedge clk);
      chk("R4 acquiring", state, 1);
      repeat (3) @(negedge clk);
      pll_lock = 1'b1;                 // 6 edges after switch
      repeat (2) @(negedge clk);
      chk("R4 locked", state, 2);
      chk("R9 locked degrade", degrade, 0);
      repeat (3) @(negedge clk);
      read_ev("R3 switch", 0, 2, 6);
      repeat (4) @(negedge clk);
      pll_lock = 1'b0;                 // locked for 10 edges

      // R5/R6 short holdover
      repeat (2) @(negedge clk);
      chk("R4 holdover", state, 3);
      chk("R5 R6 alarm", alarm, 4'b0011);
      chk("R5 lol_src", lol_src, 2);
      chk("R9 holdover degrade", degrade, 1);
      repeat (2) @(negedge clk);
      read_ev("R5 loss", 1, 2, 10);
      repeat (3) @(negedge clk);
      pll_lock = 1'b1;                 // 8 edges of holdover
      repeat (3) @(negedge clk);
      chk("R4 relocked", state, 2);
      chk("R5 alarm cleared", alarm, 0);
      read_ev("R6 exit", 2, 2, 8);
      pll_lock = 1'b0;                 // locked for 3 edges

      // R7 long holdover
      repeat (25) @(negedge clk);
      chk("R7 service alarm", alarm, 4'b1011);
      read_ev("R5 loss2", 1, 2, 3);
      read_ev("R7 limit", 4, 2, 20);
      repeat (3) @(negedge clk);
      pll_lock = 1'b1;                 // 30 edges of holdover
      repeat (3) @(negedge clk);
      chk("R7 service cleared", alarm, 0);
      chk("R4 relocked2", state, 2);
      read_ev("R6 exit2", 2, 2, 30);

      // R8 time steps: window 97..103, with wraparound
      sample("R8 first", 32'hFFFF_FFC0, 0);
      sample("R8 wrap 100", 32'h0000_0024, 0);
      sample("R8 upper edge", 32'h0000_008B, 0);
      sample("R8 lower edge", 32'h0000_00EC, 0);
      sample("R8 above", 32'h0000_0154, 1);
      sample("R8 below", 32'h0000_01B4, 1);
      sample("R8 nominal", 32'h0000_0218, 0);
      repeat (2) @(negedge clk);
      read_ev("R8 jump hi", 3, 2, 104);
      read_ev("R8 jump lo", 3, 2, 96);

      // R2 upgrade, lockout and forced switch
      ref_ok = 4'b0110;
      @(negedge clk);
      chk("R2 upgrade", mux_sel, 1);
      ref_ok = 4'b0111;
      repeat (4) @(negedge clk);
      chk("R2 lockout holds", mux_sel, 1);
      repeat (2) @(negedge clk);
      chk("R2 lockout expired", mux_sel, 0);
      ref_ok = 4'b0110;
      @(negedge clk);
      chk("R2 forced switch", mux_sel, 1);
      repeat (3) @(negedge clk);
      chk("R10 queue drained", ev_valid, 0);
      chk("R4 still locked", state, 2);

      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule